// File: doc/BRIEF.md
# Erasable ROM Mode Model

This block is a cycle-based, synthesizable stand-in for a 4096-word by 8-bit ultraviolet-erasable ROM. A controller under test drives it as it would drive the real part: a 12-bit address, an active-low chip select, a two-bit code for the combined output-enable / programming-voltage pin, an 8-bit data bus into the cell array and an erase strobe. The model answers with 8-bit read data, a flag that says the data pins are being driven, and two sticky flags that report malformed program pulses.

Writes follow the one-way rule of the real cell. A bit can only go from 1 to 0 by programming. A bulk erase is the only way back to 1. A write lands only when the chip select makes one clean low pulse of the right width while high voltage is present on the enable pin. The pulse width is measured in clock ticks. Pulses that are too short or too long are rejected and flagged. The analog levels, access delays and exposure physics are left out. Outputs appear one clock after the inputs that select them.

Top module: `uvrom_model`

## Requirements
- R1: The array holds 4096 words of 8 bits. Reset clears both error flags and starts an erase sweep of 4096 cycles. After the sweep, every word reads 0xFF.
- R2: Read mode is `ce_n`=0 with `oe_lvl`=2'b00 (logic low). One clock later, `dout_en`=1 and `dout` holds the word at `addr`.
- R3: Standby is `ce_n`=1. One clock later, `dout_en`=0 and `dout`=0, whatever the value of `oe_lvl`.
- R4: With `ce_n`=0 and `oe_lvl`=2'b01 or 2'b11 (logic high), the outputs are not driven: `dout_en`=0 one clock later.
- R5: Program mode is `ce_n`=0 with `oe_lvl`=2'b10 (high voltage). The outputs are not driven in this mode, and `din` acts as the write data.
- R6: A program pulse starts in the first cycle where `ce_n` is sampled low after being high, with high voltage present. It ends in the cycle where `ce_n` is sampled high again. If high voltage is held the whole time and the number N of low-sampled cycles satisfies PULSE_MIN ≤ N ≤ PULSE_MAX (45 and 55 by default), the word is written when the pulse ends.
- R7: A committed write stores the old word ANDed with the data. Programming a word twice leaves the AND of both data values.
- R8: A pulse with N < PULSE_MIN writes nothing and sets `err_short`. The flag stays set until reset.
- R9: A pulse with N > PULSE_MAX writes nothing and sets `err_long`. The flag stays set until reset.
- R10: Nothing is written in two cases: `ce_n` held high with high voltage present (inhibit), and `ce_n` already low before high voltage arrives (a DC select).
- R11: If high voltage is removed before a pulse ends, the pulse is discarded. No write occurs and no flag is set.
- R12: A one-cycle `erase` starts a 4096-cycle sweep that sets every word to 0xFF. During the sweep, `dout_en` stays 0 and program pulses are ignored.
- R13: Address and data are captured when a pulse starts. Changes on `addr` or `din` during the pulse do not affect the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Model clock; one tick is the pulse-width unit |
| rst | input | 1 | Synchronous active-high reset; clears flags and starts an erase sweep |
| addr | input | 12 | Word address |
| ce_n | input | 1 | Active-low chip select and program strobe |
| oe_lvl | input | 2 | Enable pin level: 00 low, 01/11 high, 10 high voltage |
| din | input | 8 | Data to program |
| erase | input | 1 | One-cycle bulk erase request |
| dout | output | 8 | Read data; 0 when not driven |
| dout_en | output | 1 | Data pins driven |
| err_short | output | 1 | Sticky: a program pulse was too short |
| err_long | output | 1 | Sticky: a program pulse was too long |

## Verification
Most internal faults show up on the next read of the affected word, one clock after the read is set up. This covers a stale captured address, a wrong AND mask, or a write that fires on the wrong edge. The bench therefore reads back every word it touches, plus a word next to it. A pulse counter that is off by one only shows at the exact limits, so widths of 44, 45, 55 and 56 ticks are each driven and then read back, and the flags are sampled the clock after the pulse ends. A sweep that skips words or lets a pulse through would leave a non-0xFF word that appears only after the sweep finishes. The bench reads such words once the sweep is done.

// File: rtl/uvrom_pkg.sv
package uvrom_pkg;
  typedef enum logic [1:0] {
    OE_LOW  = 2'b00,
    OE_HIGH = 2'b01,
    OE_VPP  = 2'b10,
    OE_HI2  = 2'b11
  } oe_lvl_t;

  typedef enum logic [1:0] {
    MODE_READ,
    MODE_DISABLE,
    MODE_PROGRAM,
    MODE_STANDBY
  } rom_mode_t;
endpackage

// File: rtl/uvrom_mode_dec.sv
module uvrom_mode_dec
  import uvrom_pkg::*;
(
  input  logic      ce_n,
  input  logic [1:0] oe_lvl,
  output rom_mode_t mode,
  output logic      vpp_on
);
  always_comb begin
    vpp_on = (oe_lvl == OE_VPP);
    if (ce_n)                  mode = MODE_STANDBY;
    else if (vpp_on)           mode = MODE_PROGRAM;
    else if (oe_lvl == OE_LOW) mode = MODE_READ;
    else                       mode = MODE_DISABLE;
  end
endmodule

// File: rtl/uvrom_erase_seq.sv
module uvrom_erase_seq #(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              erase,
  output logic              erasing,
  output logic [ADDR_W-1:0] ers_addr
);
  localparam logic [ADDR_W-1:0] LAST = {ADDR_W{1'b1}};

  always_ff @(posedge clk) begin
    if (rst) begin
      erasing  <= 1'b1;
      ers_addr <= '0;
    end else if (erasing) begin
      ers_addr <= ers_addr + 1'b1;
      if (ers_addr == LAST) erasing <= 1'b0;
    end else if (erase) begin
      erasing  <= 1'b1;
      ers_addr <= '0;
    end
  end

  // R12: a running sweep walks the address space one word per clock
  assert_sweep_step_R12: assert property (@(posedge clk) disable iff (rst)
    (erasing && ers_addr != LAST) |=> (erasing && ers_addr == $past(ers_addr) + 1'b1));
endmodule

// File: rtl/uvrom_pulse_timer.sv
module uvrom_pulse_timer #(
  parameter int ADDR_W    = 12,
  parameter int DATA_W    = 8,
  parameter int PULSE_MIN = 45,
  parameter int PULSE_MAX = 55
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ce_n,
  input  logic              vpp_on,
  input  logic              block,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  output logic              armed,
  output logic [ADDR_W-1:0] lat_addr,
  output logic [DATA_W-1:0] lat_din,
  output logic              commit,
  output logic              err_short,
  output logic              err_long
);
  localparam int CNT_W = $clog2(PULSE_MAX + 2);
  localparam logic [CNT_W-1:0] CNT_SAT = CNT_W'(PULSE_MAX + 1);
  localparam logic [CNT_W-1:0] CNT_MIN = CNT_W'(PULSE_MIN);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(PULSE_MAX);

  logic             ce_q;
  logic [CNT_W-1:0] cnt;
  logic             fall, rise, abort, in_range;

  always_comb begin
    fall     = !armed && ce_q && !ce_n && vpp_on && !block;
    abort    = armed && (!vpp_on || block);
    rise     = armed && !abort && ce_n;
    in_range = (cnt >= CNT_MIN) && (cnt <= CNT_MAX);
    commit   = rise && in_range;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ce_q      <= 1'b1;
      armed     <= 1'b0;
      cnt       <= '0;
      lat_addr  <= '0;
      lat_din   <= '0;
      err_short <= 1'b0;
      err_long  <= 1'b0;
    end else begin
      ce_q <= ce_n;
      if (fall) begin
        armed    <= 1'b1;
        cnt      <= CNT_W'(1);
        lat_addr <= addr;
        lat_din  <= din;
      end else if (abort) begin
        armed <= 1'b0;
      end else if (rise) begin
        armed <= 1'b0;
        if (cnt < CNT_MIN) err_short <= 1'b1;
        if (cnt > CNT_MAX) err_long  <= 1'b1;
      end else if (armed && cnt != CNT_SAT) begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  // R6: a write only fires on the release of a select that was low, under high voltage
  assert_commit_on_release_R6: assert property (@(posedge clk) disable iff (rst)
    commit |-> (ce_n && !ce_q && vpp_on));
  // R8: the short-pulse flag never clears without reset
  assert_short_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    err_short |=> err_short);
  // R9: the long-pulse flag never clears without reset
  assert_long_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    err_long |=> err_long);
  // R13: captured address holds for the whole pulse
  assert_latch_hold_R13: assert property (@(posedge clk) disable iff (rst)
    (armed && !fall) |=> (!armed || $stable(lat_addr)));
endmodule

// File: rtl/uvrom_array.sv
module uvrom_array #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] wa,
  input  logic [DATA_W-1:0] wd,
  input  logic [ADDR_W-1:0] ra,
  output logic [DATA_W-1:0] rq
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[wa] <= wd;
    rq <= mem[ra];
  end
endmodule

// File: rtl/uvrom_model.sv
module uvrom_model
  import uvrom_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int DATA_W    = 8,
  parameter int PULSE_MIN = 45,
  parameter int PULSE_MAX = 55
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              ce_n,
  input  logic [1:0]        oe_lvl,
  input  logic [DATA_W-1:0] din,
  input  logic              erase,
  output logic [DATA_W-1:0] dout,
  output logic              dout_en,
  output logic              err_short,
  output logic              err_long
);
  rom_mode_t         mode;
  logic              vpp_on;
  logic              erasing;
  logic [ADDR_W-1:0] ers_addr;
  logic              armed, commit;
  logic [ADDR_W-1:0] lat_addr;
  logic [DATA_W-1:0] lat_din;
  logic              we;
  logic [ADDR_W-1:0] wa, ra;
  logic [DATA_W-1:0] wd, rq;

  uvrom_mode_dec u_dec (
    .ce_n   (ce_n),
    .oe_lvl (oe_lvl),
    .mode   (mode),
    .vpp_on (vpp_on)
  );

  uvrom_erase_seq #(.ADDR_W(ADDR_W)) u_ers (
    .clk      (clk),
    .rst      (rst),
    .erase    (erase),
    .erasing  (erasing),
    .ers_addr (ers_addr)
  );

  uvrom_pulse_timer #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .PULSE_MIN(PULSE_MIN), .PULSE_MAX(PULSE_MAX)
  ) u_tmr (
    .clk       (clk),
    .rst       (rst),
    .ce_n      (ce_n),
    .vpp_on    (vpp_on),
    .block     (erasing),
    .addr      (addr),
    .din       (din),
    .armed     (armed),
    .lat_addr  (lat_addr),
    .lat_din   (lat_din),
    .commit    (commit),
    .err_short (err_short),
    .err_long  (err_long)
  );

  always_comb begin
    we = erasing || commit;
    wa = erasing ? ers_addr : lat_addr;
    wd = erasing ? {DATA_W{1'b1}} : (rq & lat_din);
    ra = armed ? lat_addr : addr;
  end

  uvrom_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_arr (
    .clk (clk),
    .we  (we),
    .wa  (wa),
    .wd  (wd),
    .ra  (ra),
    .rq  (rq)
  );

  always_ff @(posedge clk) begin
    if (rst) dout_en <= 1'b0;
    else     dout_en <= (mode == MODE_READ) && !erasing;
  end

  assign dout = dout_en ? rq : '0;

  // R3: a deselected part never drives on the next clock
  assert_standby_quiet_R3: assert property (@(posedge clk) disable iff (rst)
    ce_n |=> !dout_en);
  // R5: high voltage on the enable pin never lets the pins drive
  assert_vpp_quiet_R5: assert property (@(posedge clk) disable iff (rst)
    (oe_lvl == 2'b10) |=> !dout_en);
  // R2: a read selection outside a sweep drives on the next clock
  assert_read_drives_R2: assert property (@(posedge clk) disable iff (rst)
    (!ce_n && oe_lvl == 2'b00 && !erasing) |=> dout_en);
  // R12: the sweep owns the write port and blocks pulse writes
  assert_no_commit_in_sweep_R12: assert property (@(posedge clk) disable iff (rst)
    erasing |-> !commit);
endmodule

// File: tb/uvrom_model_bench.sv
`timescale 1ns/1ps
module uvrom_model_bench;
  localparam logic [1:0] L_LOW = 2'b00, L_HIGH = 2'b01, L_VPP = 2'b10;

  logic        clk = 1'b0;
  logic        rst;
  logic [11:0] addr;
  logic        ce_n;
  logic [1:0]  oe_lvl;
  logic [7:0]  din;
  logic        erase;
  logic [7:0]  dout;
  logic        dout_en, err_short, err_long;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  uvrom_model u_uvrom_model (
    .clk(clk), .rst(rst), .addr(addr), .ce_n(ce_n), .oe_lvl(oe_lvl),
    .din(din), .erase(erase), .dout(dout), .dout_en(dout_en),
    .err_short(err_short), .err_long(err_long)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic idle();
    @(negedge clk);
    ce_n = 1'b1; oe_lvl = L_HIGH; erase = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk);
    addr = a; ce_n = 1'b0; oe_lvl = L_LOW;
    @(negedge clk);
    chk({tag, " dout_en"}, dout_en, 1'b1);
    chk({tag, " dout"}, dout, exp);
    ce_n = 1'b1; oe_lvl = L_HIGH;
  endtask

  task automatic pulse(input logic [11:0] a, input logic [7:0] d, input int n);
    @(negedge clk);
    addr = a; din = d; oe_lvl = L_VPP; ce_n = 1'b1;
    @(negedge clk);
    ce_n = 1'b0;
    repeat (n) @(negedge clk);
    ce_n = 1'b1;
    @(negedge clk);
    oe_lvl = L_HIGH;
  endtask

  task automatic t_reset();
    rst = 1'b1; ce_n = 1'b1; oe_lvl = L_HIGH; din = '0; addr = '0; erase = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 reset dout_en", dout_en, 1'b0);
    chk("R1 reset err_short", err_short, 1'b0);
    chk("R1 reset err_long", err_long, 1'b0);
    repeat (4100) @(negedge clk);
    rd(12'd0, 8'hFF, "R1 word0");
    rd(12'hFFF, 8'hFF, "R1 last word");
    rd(12'd1234, 8'hFF, "R1 mid word");
  endtask

  task automatic t_modes();
    pulse(12'd5, 8'hA5, 50);
    rd(12'd5, 8'hA5, "R6 R2 program then read");
    rd(12'd6, 8'hFF, "R2 neighbour untouched");
    @(negedge clk); addr = 12'd5; ce_n = 1'b1; oe_lvl = L_LOW;
    @(negedge clk);
    chk("R3 standby dout_en", dout_en, 1'b0);
    chk("R3 standby dout", dout, 8'h00);
    @(negedge clk); ce_n = 1'b0; oe_lvl = L_HIGH;
    @(negedge clk);
    chk("R4 disabled dout_en", dout_en, 1'b0);
    @(negedge clk); ce_n = 1'b0; oe_lvl = 2'b11;
    @(negedge clk);
    chk("R4 disabled code 11 dout_en", dout_en, 1'b0);
    @(negedge clk); addr = 12'd7; din = 8'h00; ce_n = 1'b1; oe_lvl = L_VPP;
    @(negedge clk); ce_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R5 program no drive", dout_en, 1'b0);
    repeat (3) @(negedge clk);
    oe_lvl = L_HIGH;
    idle();
  endtask

  task automatic t_and();
    pulse(12'd5, 8'h3C, 50);
    rd(12'd5, 8'h24, "R7 second program ANDs");
    pulse(12'd5, 8'hFF, 50);
    rd(12'd5, 8'h24, "R7 ones never restored");
  endtask

  task automatic t_limits();
    pulse(12'd10, 8'h0F, 45);
    rd(12'd10, 8'h0F, "R6 min width writes");
    pulse(12'd11, 8'hF0, 55);
    rd(12'd11, 8'hF0, "R6 max width writes");
    chk("R6 no flag on legal widths", {err_short, err_long}, 2'b00);
    pulse(12'd12, 8'h00, 44);
    @(negedge clk);
    chk("R8 short flag", err_short, 1'b1);
    chk("R8 long flag clear", err_long, 1'b0);
    rd(12'd12, 8'hFF, "R8 short no write");
    pulse(12'd13, 8'h00, 56);
    @(negedge clk);
    chk("R9 long flag", err_long, 1'b1);
    rd(12'd13, 8'hFF, "R9 long no write");
    pulse(12'd9, 8'h00, 120);
    rd(12'd9, 8'hFF, "R9 held select no write");
  endtask

  task automatic t_inhibit();
    @(negedge clk); addr = 12'd14; din = 8'h00; ce_n = 1'b1; oe_lvl = L_VPP;
    repeat (60) @(negedge clk);
    chk("R10 inhibit no drive", dout_en, 1'b0);
    oe_lvl = L_HIGH;
    rd(12'd14, 8'hFF, "R10 inhibit no write");
    @(negedge clk); addr = 12'd15; din = 8'h00; oe_lvl = L_HIGH; ce_n = 1'b0;
    @(negedge clk); oe_lvl = L_VPP;
    repeat (50) @(negedge clk);
    ce_n = 1'b1;
    @(negedge clk); oe_lvl = L_HIGH;
    rd(12'd15, 8'hFF, "R10 DC select no write");
  endtask

  task automatic t_drop();
    logic [1:0] flags_before;
    flags_before = {err_short, err_long};
    @(negedge clk); addr = 12'd16; din = 8'h00; ce_n = 1'b1; oe_lvl = L_VPP;
    @(negedge clk); ce_n = 1'b0;
    repeat (20) @(negedge clk);
    oe_lvl = L_HIGH;
    repeat (30) @(negedge clk);
    oe_lvl = L_VPP;
    @(negedge clk); ce_n = 1'b1;
    @(negedge clk); oe_lvl = L_HIGH;
    @(negedge clk);
    chk("R11 flags unchanged", {err_short, err_long}, flags_before);
    rd(12'd16, 8'hFF, "R11 dropped voltage no write");
  endtask

  task automatic t_capture();
    @(negedge clk); addr = 12'd20; din = 8'h55; ce_n = 1'b1; oe_lvl = L_VPP;
    @(negedge clk); ce_n = 1'b0;
    @(negedge clk); addr = 12'd21; din = 8'h00;
    repeat (49) @(negedge clk);
    ce_n = 1'b1;
    @(negedge clk); oe_lvl = L_HIGH;
    rd(12'd20, 8'h55, "R13 captured address written");
    rd(12'd21, 8'hFF, "R13 later address untouched");
  endtask

  task automatic t_erase();
    @(negedge clk); erase = 1'b1;
    @(negedge clk); erase = 1'b0; addr = 12'd5; ce_n = 1'b0; oe_lvl = L_LOW;
    @(negedge clk);
    chk("R12 no drive in sweep", dout_en, 1'b0);
    ce_n = 1'b1; oe_lvl = L_HIGH;
    repeat (40) @(negedge clk);
    pulse(12'd30, 8'h00, 50);
    repeat (4100) @(negedge clk);
    rd(12'd5, 8'hFF, "R12 programmed word restored");
    rd(12'd20, 8'hFF, "R12 second word restored");
    rd(12'd30, 8'hFF, "R12 pulse in sweep ignored");
    chk("R12 flags survive erase", {err_short, err_long}, 2'b11);
  endtask

  initial begin
    t_reset();
    t_modes();
    t_and();
    t_limits();
    t_inhibit();
    t_drop();
    t_capture();
    t_erase();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule